// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write path of a byte-wide NOR-style flash controller. Each clock in which the host presents a write, the decoder examines the address and data and steps through the unlock-prefixed command sequences. When a sequence completes, it raises a single-cycle strobe for the embedded-operation engine: program, chip erase, sector erase, autoselect entry, return to read, erase suspend, erase resume, fast-mode entry, fast-mode exit or sector protect. Alongside the strobes it holds the captured target address and data and reports the current read mode. In autoselect and protect-verify modes it also supplies the identification byte for host reads.

Normal commands begin with two unlock writes. In fast mode a shorter set replaces them: a two-write program and a two-write exit. Writes made while the engine is busy are dropped, with one exception: a suspend request during a running sector erase. While an erase is suspended, erase commands are refused.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A low `rstN` sampled at a clock edge sets `mode` to read (00), clears every strobe and both latches, and abandons any partial sequence.
- R2: The unlock prefix is AAH written at 555H, then 55H written at 2AAH. Only address bits [10:0] are compared; bits above them do not affect the match.
- R3: After the unlock, A0H at 555H and then one more write produce `progStb`. `latchAddr` and `latchData` take the address and data of that final write. Outputs change one clock after the write is sampled.
- R4: Unlock, 80H at 555H, unlock, then 10H at 555H gives `chipEraseStb`. If the last write is instead 30H at any address, the result is `sectEraseStb`, and `latchAddr` takes that address.
- R5: Unlock then 90H at 555H gives `autoselStb` and sets `mode` to 01. In that mode `idData` is 04H when `rdA0`=0. When `rdA0`=1 it is C4H (with `TOP_BOOT`=1) or 49H (with `TOP_BOOT`=0). In read mode `idData` is 00H.
- R6: F0H written at any address, either alone or after the unlock, gives `resetStb`, returns `mode` to 00 and discards the partial sequence.
- R7: Any write that does not match the expected next step returns the decoder to its idle state with no strobe. The rejected write cannot serve as a later step.
- R8: While `busy` is high, writes are ignored and produce no strobe, and `mode` is unchanged. The one exception is B0H while `sectErasing` is high, which gives `suspendStb` and enters the suspended state. In the suspended state, 30H at any address gives `resumeStb` and leaves it.
- R9: In the suspended state, chip-erase and sector-erase sequences give no strobe, while program still works.
- R10: Unlock then 20H at 555H gives `fastEnterStb` and sets `mode` to 10. In fast mode, A0H followed by one write gives `progStb` with the latches updated. 90H then F0H, at any addresses, gives `fastExitStb` and sets `mode` to 00. Other writes leave `mode` at 10.
- R11: The writes 60H, 60H and 40H, each at an address with bits (6,1,0)=(0,1,0), give `protectStb` and set `mode` to 11, with `latchAddr` taking the last address. In that mode `idData` equals {7'b0, `sectProtected`}. A write at an address whose low bits differ breaks the sequence.
- R12: Every strobe lasts exactly one cycle, at most one strobe is high at a time, and a strobe only follows a sampled write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Host write cycle valid this clock |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| busy | input | 1 | Embedded-operation engine busy |
| sectErasing | input | 1 | Engine is running a sector erase |
| rdA0 | input | 1 | Bit 0 of the current read address |
| sectProtected | input | 1 | Protection status of the addressed sector |
| progStb | output | 1 | Program command strobe |
| chipEraseStb | output | 1 | Chip erase strobe |
| sectEraseStb | output | 1 | Sector erase strobe |
| autoselStb | output | 1 | Autoselect entry strobe |
| resetStb | output | 1 | Return-to-read strobe |
| suspendStb | output | 1 | Erase suspend strobe |
| resumeStb | output | 1 | Erase resume strobe |
| fastEnterStb | output | 1 | Fast-mode entry strobe |
| fastExitStb | output | 1 | Fast-mode exit strobe |
| protectStb | output | 1 | Sector protect strobe |
| mode | output | 2 | 00 read, 01 autoselect, 10 fast, 11 protect verify |
| latchAddr | output | ADDR_W | Captured program, sector or protect address |
| latchData | output | 8 | Captured program data |
| idData | output | 8 | Identification or protect-verify byte |

## Verification
Directed sequences cover each command with nonzero upper address bits, to show that only the low bits take part in the match. Broken prefixes, with a wrong address or a wrong byte, show that mismatches reset the sequence. Busy, suspended and fast-mode runs separate the three filters that gate the command set. Random garbage writes in read mode tell a tolerant idle state apart from one that leaks strobes. Random program targets and data show that the latches capture the final write rather than an earlier step.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_READ    = 2'b00,
    MODE_AUTOSEL = 2'b01,
    MODE_FAST    = 2'b10,
    MODE_PROTV   = 2'b11
  } mode_e;

  // Command bytes
  localparam logic [7:0] BYTE_UNLK1   = 8'hAA;
  localparam logic [7:0] BYTE_UNLK2   = 8'h55;
  localparam logic [7:0] BYTE_PROG    = 8'hA0;
  localparam logic [7:0] BYTE_ERASE   = 8'h80;
  localparam logic [7:0] BYTE_CHIP    = 8'h10;
  localparam logic [7:0] BYTE_SECT    = 8'h30;
  localparam logic [7:0] BYTE_IDENT   = 8'h90;
  localparam logic [7:0] BYTE_RESET   = 8'hF0;
  localparam logic [7:0] BYTE_SUSPEND = 8'hB0;
  localparam logic [7:0] BYTE_FAST    = 8'h20;
  localparam logic [7:0] BYTE_PROT1   = 8'h60;
  localparam logic [7:0] BYTE_PROT2   = 8'h40;

  // Control to datapath
  typedef struct packed {
    logic  capProg;
    logic  capAddr;
    logic  modeWr;
    mode_e modeNew;
  } dp_ctrl_t;

  // Registered strobes
  typedef struct packed {
    logic prog;
    logic chipErase;
    logic sectErase;
    logic autosel;
    logic reset;
    logic suspend;
    logic resume;
    logic fastEnter;
    logic fastExit;
    logic protect;
  } stb_t;

endpackage

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int CMP_W    = 11,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdA0,
  input  logic              sectProtected,
  input  dp_ctrl_t          ctrl,
  output logic              hitA1,
  output logic              hitA2,
  output logic              protAddrOk,
  output mode_e             modeQ,
  output logic [ADDR_W-1:0] latchAddr,
  output logic [7:0]        latchData,
  output logic [7:0]        idData
);

  localparam logic [CMP_W-1:0] UNLK_ADDR1 = CMP_W'(12'h555);
  localparam logic [CMP_W-1:0] UNLK_ADDR2 = CMP_W'(12'h2AA);
  localparam logic [7:0]       MFR_CODE   = 8'h04;

  logic [7:0] devCode;

  generate
    if (TOP_BOOT) begin : g_top
      assign devCode = 8'hC4;
    end else begin : g_bottom
      assign devCode = 8'h49;
    end
  endgenerate

  assign hitA1      = (wrAddr[CMP_W-1:0] == UNLK_ADDR1);
  assign hitA2      = (wrAddr[CMP_W-1:0] == UNLK_ADDR2);
  assign protAddrOk = ({wrAddr[6], wrAddr[1], wrAddr[0]} == 3'b010);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_READ;
      latchAddr <= '0;
      latchData <= '0;
    end else begin
      if (ctrl.modeWr) modeQ <= ctrl.modeNew;
      if (ctrl.capProg || ctrl.capAddr) latchAddr <= wrAddr;
      if (ctrl.capProg) latchData <= wrData;
    end
  end

  always_comb begin
    unique case (modeQ)
      MODE_AUTOSEL: idData = rdA0 ? devCode : MFR_CODE;
      MODE_PROTV:   idData = {7'b0, sectProtected};
      default:      idData = 8'h00;
    endcase
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       hitA1,
  input  logic       hitA2,
  input  logic       protAddrOk,
  input  logic       busy,
  input  logic       sectErasing,
  input  mode_e      modeQ,
  output dp_ctrl_t   ctrl,
  output stb_t       stbQ
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E1, ST_EU1, ST_EU2,
    ST_FIDLE, ST_FPGM, ST_FEXIT, ST_P1, ST_P2
  } st_e;

  st_e  stateQ, stateD;
  logic suspQ, suspD;
  stb_t stbD;

  function automatic st_e homeOf(input mode_e m);
    return (m == MODE_FAST) ? ST_FIDLE : ST_IDLE;
  endfunction

  always_comb begin
    stateD = stateQ;
    suspD  = suspQ;
    stbD   = '0;
    ctrl   = '{capProg: 1'b0, capAddr: 1'b0, modeWr: 1'b0, modeNew: MODE_READ};
    if (wrEn) begin
      if (busy) begin
        if (sectErasing && !suspQ && wrData == BYTE_SUSPEND) begin
          stbD.suspend = 1'b1;
          suspD        = 1'b1;
        end
      end else if (suspQ && wrData == BYTE_SECT) begin
        stbD.resume = 1'b1;
        suspD       = 1'b0;
        stateD      = homeOf(modeQ);
      end else if (wrData == BYTE_RESET && stateQ != ST_FEXIT) begin
        stbD.reset   = 1'b1;
        ctrl.modeWr  = 1'b1;
        ctrl.modeNew = MODE_READ;
        stateD       = ST_IDLE;
      end else begin
        unique case (stateQ)
          ST_IDLE: begin
            if (wrData == BYTE_UNLK1 && hitA1) stateD = ST_U1;
            else if (wrData == BYTE_PROT1 && protAddrOk) stateD = ST_P1;
            else stateD = ST_IDLE;
          end
          ST_U1: stateD = (wrData == BYTE_UNLK2 && hitA2) ? ST_U2 : ST_IDLE;
          ST_U2: begin
            stateD = ST_IDLE;
            if (hitA1) begin
              case (wrData)
                BYTE_PROG:  stateD = ST_PGM;
                BYTE_ERASE: stateD = suspQ ? ST_IDLE : ST_E1;
                BYTE_IDENT: begin
                  stbD.autosel = 1'b1;
                  ctrl.modeWr  = 1'b1;
                  ctrl.modeNew = MODE_AUTOSEL;
                end
                BYTE_FAST: begin
                  stbD.fastEnter = 1'b1;
                  ctrl.modeWr    = 1'b1;
                  ctrl.modeNew   = MODE_FAST;
                  stateD         = ST_FIDLE;
                end
                default: stateD = ST_IDLE;
              endcase
            end
          end
          ST_PGM: begin
            stbD.prog    = 1'b1;
            ctrl.capProg = 1'b1;
            stateD       = ST_IDLE;
          end
          ST_E1:  stateD = (wrData == BYTE_UNLK1 && hitA1) ? ST_EU1 : ST_IDLE;
          ST_EU1: stateD = (wrData == BYTE_UNLK2 && hitA2) ? ST_EU2 : ST_IDLE;
          ST_EU2: begin
            stateD = ST_IDLE;
            if (wrData == BYTE_CHIP && hitA1) begin
              stbD.chipErase = 1'b1;
            end else if (wrData == BYTE_SECT) begin
              stbD.sectErase = 1'b1;
              ctrl.capAddr   = 1'b1;
            end
          end
          ST_FIDLE: begin
            if (wrData == BYTE_PROG) stateD = ST_FPGM;
            else if (wrData == BYTE_IDENT) stateD = ST_FEXIT;
            else stateD = ST_FIDLE;
          end
          ST_FPGM: begin
            stbD.prog    = 1'b1;
            ctrl.capProg = 1'b1;
            stateD       = ST_FIDLE;
          end
          ST_FEXIT: begin
            if (wrData == BYTE_RESET) begin
              stbD.fastExit = 1'b1;
              ctrl.modeWr   = 1'b1;
              ctrl.modeNew  = MODE_READ;
              stateD        = ST_IDLE;
            end else begin
              stateD = ST_FIDLE;
            end
          end
          ST_P1: stateD = (wrData == BYTE_PROT1 && protAddrOk) ? ST_P2 : ST_IDLE;
          ST_P2: begin
            stateD = ST_IDLE;
            if (wrData == BYTE_PROT2 && protAddrOk) begin
              stbD.protect = 1'b1;
              ctrl.capAddr = 1'b1;
              ctrl.modeWr  = 1'b1;
              ctrl.modeNew = MODE_PROTV;
            end
          end
          default: stateD = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      suspQ  <= 1'b0;
      stbQ   <= '0;
    end else begin
      stateQ <= stateD;
      suspQ  <= suspD;
      stbQ   <= stbD;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int CMP_W    = 11,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  input  logic              sectErasing,
  input  logic              rdA0,
  input  logic              sectProtected,
  output logic              progStb,
  output logic              chipEraseStb,
  output logic              sectEraseStb,
  output logic              autoselStb,
  output logic              resetStb,
  output logic              suspendStb,
  output logic              resumeStb,
  output logic              fastEnterStb,
  output logic              fastExitStb,
  output logic              protectStb,
  output logic [1:0]        mode,
  output logic [ADDR_W-1:0] latchAddr,
  output logic [7:0]        latchData,
  output logic [7:0]        idData
);

  dp_ctrl_t ctrl;
  stb_t     stbQ;
  mode_e    modeQ;
  logic     hitA1, hitA2, protAddrOk;

  flash_cmd_fsm i_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .hitA1      (hitA1),
    .hitA2      (hitA2),
    .protAddrOk (protAddrOk),
    .busy       (busy),
    .sectErasing(sectErasing),
    .modeQ      (modeQ),
    .ctrl       (ctrl),
    .stbQ       (stbQ)
  );

  flash_cmd_datapath #(
    .ADDR_W  (ADDR_W),
    .CMP_W   (CMP_W),
    .TOP_BOOT(TOP_BOOT)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .rdA0         (rdA0),
    .sectProtected(sectProtected),
    .ctrl         (ctrl),
    .hitA1        (hitA1),
    .hitA2        (hitA2),
    .protAddrOk   (protAddrOk),
    .modeQ        (modeQ),
    .latchAddr    (latchAddr),
    .latchData    (latchData),
    .idData       (idData)
  );

  assign progStb      = stbQ.prog;
  assign chipEraseStb = stbQ.chipErase;
  assign sectEraseStb = stbQ.sectErase;
  assign autoselStb   = stbQ.autosel;
  assign resetStb     = stbQ.reset;
  assign suspendStb   = stbQ.suspend;
  assign resumeStb    = stbQ.resume;
  assign fastEnterStb = stbQ.fastEnter;
  assign fastExitStb  = stbQ.fastExit;
  assign protectStb   = stbQ.protect;
  assign mode         = modeQ;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       busy,
  input logic       sectErasing,
  input logic       progStb,
  input logic       chipEraseStb,
  input logic       sectEraseStb,
  input logic       autoselStb,
  input logic       resetStb,
  input logic       suspendStb,
  input logic       resumeStb,
  input logic       fastEnterStb,
  input logic       fastExitStb,
  input logic       protectStb,
  input logic [1:0] mode,
  input logic [7:0] latchData
);

  logic [9:0] stbs;
  assign stbs = {progStb, chipEraseStb, sectEraseStb, autoselStb, resetStb,
                 suspendStb, resumeStb, fastEnterStb, fastExitStb, protectStb};

  AST_RST_CLEARS: assert property (@(posedge clk) !rstN |=> (mode == 2'b00 && stbs == 10'b0)); // R1
  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(stbs)); // R12
  AST_STB_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN) (|stbs) |-> $past(wrEn)); // R12
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rstN) (wrEn && busy && !sectErasing) |=> (stbs == 10'b0)); // R8
  AST_SUSPEND_COND: assert property (@(posedge clk) disable iff (!rstN) suspendStb |-> $past(busy && sectErasing && wrData == 8'hB0)); // R8
  AST_PROG_DATA: assert property (@(posedge clk) disable iff (!rstN) progStb |-> (latchData == $past(wrData))); // R3
  AST_AUTOSEL_MODE: assert property (@(posedge clk) disable iff (!rstN) autoselStb |-> (mode == 2'b01)); // R5
  AST_RESET_MODE: assert property (@(posedge clk) disable iff (!rstN) resetStb |-> (mode == 2'b00)); // R6
  AST_FAST_ENTER: assert property (@(posedge clk) disable iff (!rstN) fastEnterStb |-> (mode == 2'b10)); // R10
  AST_FAST_EXIT: assert property (@(posedge clk) disable iff (!rstN) fastExitStb |-> (mode == 2'b00)); // R10
  AST_PROT_MODE: assert property (@(posedge clk) disable iff (!rstN) protectStb |-> (mode == 2'b11)); // R11

endmodule

bind flash_cmd_decoder flash_cmd_checker i_chk (.*);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

  localparam int  ADDR_W = 21;
  localparam time CYC    = 20ns;

  localparam logic [9:0] S_NONE  = 10'b0;
  localparam logic [9:0] S_PROG  = 10'b1000000000;
  localparam logic [9:0] S_CHIP  = 10'b0100000000;
  localparam logic [9:0] S_SECT  = 10'b0010000000;
  localparam logic [9:0] S_AUTO  = 10'b0001000000;
  localparam logic [9:0] S_RST   = 10'b0000100000;
  localparam logic [9:0] S_SUSP  = 10'b0000010000;
  localparam logic [9:0] S_RES   = 10'b0000001000;
  localparam logic [9:0] S_FENT  = 10'b0000000100;
  localparam logic [9:0] S_FEXT  = 10'b0000000010;
  localparam logic [9:0] S_PROT  = 10'b0000000001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic busy = 1'b0, sectErasing = 1'b0, rdA0 = 1'b0, sectProtected = 1'b0;
  logic progStb, chipEraseStb, sectEraseStb, autoselStb, resetStb;
  logic suspendStb, resumeStb, fastEnterStb, fastExitStb, protectStb;
  logic [1:0] mode;
  logic [ADDR_W-1:0] latchAddr;
  logic [7:0] latchData, idData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CYC/2) clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (.*);

  function automatic logic [9:0] stbVec();
    return {progStb, chipEraseStb, sectEraseStb, autoselStb, resetStb,
            suspendStb, resumeStb, fastEnterStb, fastExitStb, protectStb};
  endfunction

  function automatic logic [7:0] safeGarbage(input logic [7:0] d);
    return (d == 8'hAA || d == 8'hF0 || d == 8'h60) ? 8'h11 : d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one write; returns at the negedge where its strobe is visible.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrChk(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       input logic [9:0] exp, input string req);
    wr(a, d);
    chk(req, {22'b0, stbVec()}, {22'b0, exp});
  endtask

  task automatic unlock();
    wrChk(21'h000555, 8'hAA, S_NONE, "R2");
    wrChk(21'h0002AA, 8'h55, S_NONE, "R2");
  endtask

  initial begin
    #(CYC * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", {30'b0, mode}, 0);
    chk("R1 strobes", {22'b0, stbVec()}, 0);
    chk("R1 latchAddr", {11'b0, latchAddr}, 0);
    chk("R1 latchData", {24'b0, latchData}, 0);
    rstN = 1'b1;

    // R2 R3 program with upper address bits set
    wrChk(21'h1A0555, 8'hAA, S_NONE, "R2");
    wrChk(21'h0FF2AA, 8'h55, S_NONE, "R2");
    wrChk(21'h155555, 8'hA0, S_NONE, "R3");
    wrChk(21'h123456, 8'h5A, S_PROG, "R3");
    chk("R3 addr", {11'b0, latchAddr}, 32'h123456);
    chk("R3 data", {24'b0, latchData}, 32'h5A);
    @(negedge clk);
    chk("R12 one cycle", {22'b0, stbVec()}, 0);

    // R4 chip erase and sector erase
    unlock(); wrChk(21'h555, 8'h80, S_NONE, "R4");
    unlock(); wrChk(21'h555, 8'h10, S_CHIP, "R4 chip");
    unlock(); wrChk(21'h555, 8'h80, S_NONE, "R4");
    unlock(); wrChk(21'h1F4000, 8'h30, S_SECT, "R4 sector");
    chk("R4 sector addr", {11'b0, latchAddr}, 32'h1F4000);

    // R5 autoselect
    unlock(); wrChk(21'h555, 8'h90, S_AUTO, "R5");
    chk("R5 mode", {30'b0, mode}, 1);
    rdA0 = 1'b0; #1;
    chk("R5 mfr", {24'b0, idData}, 32'h04);
    rdA0 = 1'b1; #1;
    chk("R5 dev", {24'b0, idData}, 32'hC4);

    // R8 busy ignores F0
    busy = 1'b1;
    wrChk(21'h7777, 8'hF0, S_NONE, "R8 busy");
    chk("R8 mode kept", {30'b0, mode}, 1);
    busy = 1'b0;

    // R6 single reset
    wrChk(21'h7777, 8'hF0, S_RST, "R6 single");
    chk("R6 mode", {30'b0, mode}, 0);
    #1 chk("R5 read id", {24'b0, idData}, 0);
    // R6 three-cycle and abort
    unlock(); wrChk(21'h555, 8'hF0, S_RST, "R6 three");
    unlock(); wrChk(21'h123, 8'hF0, S_RST, "R6 abort");
    wrChk(21'h555, 8'hA0, S_NONE, "R6 abort");
    wrChk(21'h400, 8'h33, S_NONE, "R6 abort");

    // R7 mismatch
    wrChk(21'h555, 8'hAA, S_NONE, "R7");
    wrChk(21'h2AB, 8'h55, S_NONE, "R7 bad addr");
    wrChk(21'h555, 8'hA0, S_NONE, "R7");
    wrChk(21'h100, 8'h33, S_NONE, "R7 no prog");
    unlock(); wrChk(21'h555, 8'hA5, S_NONE, "R7 bad byte");
    wrChk(21'h100, 8'h33, S_NONE, "R7 no prog");

    // R8 busy program ignored; suspend/resume
    busy = 1'b1;
    wrChk(21'h555, 8'hAA, S_NONE, "R8");
    wrChk(21'h2AA, 8'h55, S_NONE, "R8");
    wrChk(21'h555, 8'hA0, S_NONE, "R8");
    wrChk(21'h222, 8'h44, S_NONE, "R8 busy prog");
    sectErasing = 1'b1;
    wrChk(21'h000, 8'hB0, S_SUSP, "R8 suspend");
    busy = 1'b0; sectErasing = 1'b0;
    // R9 erase refused while suspended
    unlock(); wrChk(21'h555, 8'h80, S_NONE, "R9");
    unlock(); wrChk(21'h555, 8'h10, S_NONE, "R9 chip refused");
    unlock(); wrChk(21'h555, 8'hA0, S_NONE, "R9");
    wrChk(21'h0ABC, 8'h77, S_PROG, "R9 prog ok");
    chk("R9 data", {24'b0, latchData}, 32'h77);
    wrChk(21'h005, 8'h30, S_RES, "R8 resume");

    // R10 fast mode
    unlock(); wrChk(21'h555, 8'h20, S_FENT, "R10 enter");
    chk("R10 mode", {30'b0, mode}, 2);
    wrChk(21'h0001, 8'hA0, S_NONE, "R10");
    wrChk(21'h0ABCDE, 8'h3C, S_PROG, "R10 prog");
    chk("R10 addr", {11'b0, latchAddr}, 32'h0ABCDE);
    wrChk(21'h0009, 8'h55, S_NONE, "R10 other");
    chk("R10 mode kept", {30'b0, mode}, 2);
    wrChk(21'h0001, 8'h90, S_NONE, "R10");
    wrChk(21'h0002, 8'hF0, S_FEXT, "R10 exit");
    chk("R10 exit mode", {30'b0, mode}, 0);

    // R11 protect
    wrChk(21'h1F8002, 8'h60, S_NONE, "R11");
    wrChk(21'h1F8002, 8'h60, S_NONE, "R11");
    wrChk(21'h1F8002, 8'h40, S_PROT, "R11 protect");
    chk("R11 mode", {30'b0, mode}, 3);
    chk("R11 addr", {11'b0, latchAddr}, 32'h1F8002);
    sectProtected = 1'b1; #1;
    chk("R11 verify 1", {24'b0, idData}, 1);
    sectProtected = 1'b0; #1;
    chk("R11 verify 0", {24'b0, idData}, 0);
    wrChk(21'h0, 8'hF0, S_RST, "R6");
    wrChk(21'h1F8003, 8'h60, S_NONE, "R11 bad addr");
    wrChk(21'h1F8002, 8'h60, S_NONE, "R11");
    wrChk(21'h1F8002, 8'h40, S_NONE, "R11 broken");

    // Random: garbage in read idle, then random programs
    for (int i = 0; i < 40; i++) begin
      logic [ADDR_W-1:0] ra;
      logic [7:0] rd;
      ra = ADDR_W'($urandom);
      rd = safeGarbage(8'($urandom));
      wrChk(ra, rd, S_NONE, "R7 random idle");
      chk("R7 random mode", {30'b0, mode}, 0);
    end
    for (int i = 0; i < 30; i++) begin
      logic [ADDR_W-1:0] pa;
      logic [7:0] pd;
      pa = ADDR_W'($urandom);
      pd = 8'($urandom);
      if (pd == 8'hF0) pd = 8'h0F;
      wrChk(21'h555 | (ADDR_W'($urandom) & 21'h1FF800), 8'hAA, S_NONE, "R2 random");
      wrChk(21'h2AA | (ADDR_W'($urandom) & 21'h1FF800), 8'h55, S_NONE, "R2 random");
      wrChk(21'h555, 8'hA0, S_NONE, "R3 random");
      wrChk(pa, pd, S_PROG, "R3 random");
      chk("R3 random addr", {11'b0, latchAddr}, {11'b0, pa});
      chk("R3 random data", {24'b0, latchData}, {24'b0, pd});
    end

    // R1 mid-sequence reset
    unlock(); wrChk(21'h555, 8'h20, S_FENT, "R10");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk("R1 reset mode", {30'b0, mode}, 0);
    wrChk(21'h0, 8'hA0, S_NONE, "R1 no fast");
    wrChk(21'h1, 8'h12, S_NONE, "R1 no fast");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule